// File: doc/BRIEF.md
# MDIO Management Frame Engine over a Host Register

This block carries out one MII management (MDIO) read or write to an Ethernet PHY. It never touches the MDIO pins. It reaches them only through a host-side management register whose bits drive the management clock, the data-out value and the data-out enable, and which returns the sampled MDI level. Each frame bit takes three register accesses. The first is a write with the clock low and the bit's data and enable applied. The second is a write with the same data and enable and the clock high. The third is a read that picks up MDI.

A request gives the direction, a 5-bit PHY address, a 5-bit register address and, for writes, 16 data bits. The engine reaches the register through a request/acknowledge port to an outside register-access machine. A pace counter limits that port to one access per `PACE_DIV` system clocks. The default of 4096 gives about 10 kHz per access from a 40 MHz clock. When the last of the 64 bit cycles completes, `done` pulses for one cycle. For a read, `rd_data` then holds the 16 bits returned by the PHY.

Top module: `mdio_bb_engine`

## Requirements
- R1: A transaction is exactly 64 bit cycles. Every bit cycle is three accesses in this order: a write with the clock bit (bit 2) at 0, then a write with the clock bit at 1 and the same data-out (bit 0) and enable (bit 3) values, then a read. No access takes place while `busy` is low.
- R2: Frame bits are sent in this order: 32 ones, then 0,1, then the opcode (1,0 for a read; 0,1 for a write), then the PHY address MSB first, then the register address MSB first, then the turnaround (1,0 for a write; 1,1 for a read), then 16 data bits MSB first (the write data for a write; all ones for a read).
- R3: In a read, data-out enable (bit 3) is 1 in bit cycles 0 to 45 and 0 in bit cycles 46 to 63. In a write it is 1 in all 64 bit cycles.
- R4: For a read, `rd_data` holds the MDI bit (bit 1) sampled by the read access of bit cycles 48 to 63, MSB first. It is valid when `done` pulses. A write transaction leaves `rd_data` unchanged.
- R5: Every register write carries `BASE_VAL` in every bit other than bits 0 to 3. MDI (bit 1) is written as 0.
- R6: Each access starts one clock after a pace tick. Ticks come every `PACE_DIV` clocks while busy. Successive access starts are therefore a nonzero multiple of `PACE_DIV` clocks apart.
- R7: Once raised, `reg_req` stays high with stable `reg_we` and `reg_wdata` until `reg_ack` is seen.
- R8: A `start` that arrives while `busy` is high is ignored, and the frame in progress continues unchanged.
- R9: After reset, `busy`, `done` and `reg_req` are 0 and `rd_data` is 0.
- R10: `done` is high for exactly one cycle. `busy` is low in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transaction (accepted when idle) |
| op_write | input | 1 | 1 = write, 0 = read |
| phy_addr | input | 5 | PHY address |
| reg_addr | input | 5 | PHY register address |
| wr_data | input | 16 | Data for a write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Data returned by the last read |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | 1 = register write, 0 = register read |
| reg_wdata | output | 16 | Value to write to the management register |
| reg_rdata | input | 16 | Register value returned on a read |
| reg_ack | input | 1 | Access complete |

## Verification
The bench models a PHY behind the register. The model samples data-out on each clock-rising write and answers reads with a chosen pattern. It drives a pull-up 1 where it does not drive, so an engine that sampled the wrong cycles or in the wrong bit order would return a shifted or all-ones word. Read patterns 0x0001 and 0xA5C3 expose an off-by-one in the data window and a reversed MSB order. Write data 0xFFFF and 0x8000 expose a stuck or reversed data field. A start pulse with different fields during a write would corrupt the captured frame if the engine accepted it. A write that follows a read would show a changed `rd_data` if writes overwrote the read result. Ack latencies of one to three cycles, against a short pace period, expose an access that moves on before its acknowledge or starts off the pace grid.

// File: rtl/mdio_bb_pkg.sv
// Shared constants and types for the MDIO register-driven frame engine.
// Assumes a fixed 64-bit management frame with data in its last 16 cycles.
package mdio_bb_pkg;
    localparam int FRAME_BITS = 64;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int DATA_W     = 16;
    localparam int ADDR_W     = 5;
    localparam int DATA_START = FRAME_BITS - DATA_W;   // first data bit cycle
    localparam int TA_START   = DATA_START - 2;        // first turnaround cycle

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_WAIT,
        SQ_ACC
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_LO,
        PH_HI,
        PH_RD
    } bit_phase_t;
endpackage

// File: rtl/mdio_bb_pacer.sv
// Pace counter: while enabled, raises tick for one cycle every DIV clocks.
// Assumes DIV >= 2. The count restarts at zero whenever enable drops.
module mdio_bb_pacer #(
    parameter int DIV = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    // Count clocks while enabled and wrap at DIV-1.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = en && (cnt_q == LAST);

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R6
endmodule

// File: rtl/mdio_bb_frame.sv
// Frame builder: gives the data-out and enable values for one bit cycle of
// a management frame, selected by bit index (0 = first bit on the wire).
// Assumes the request fields are held stable for the whole transaction.
module mdio_bb_frame
    import mdio_bb_pkg::*;
(
    input  logic              op_write,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  bit_idx,
    output logic              mdo,
    output logic              mdoe
);
    logic [FRAME_BITS-1:0] frame_vec;
    logic [FRAME_BITS-1:0] oe_read;

    // Read frames release the line from the turnaround to the end.
    for (genvar g = 0; g < FRAME_BITS; g++) begin : g_oe
        assign oe_read[FRAME_BITS-1-g] = (g < TA_START);
    end

    // Assemble the frame with bit cycle 0 in the MSB.
    always_comb begin
        frame_vec = {32'hFFFF_FFFF, 2'b01,
                     op_write ? 2'b01 : 2'b10,
                     phy_addr, reg_addr,
                     op_write ? 2'b10 : 2'b11,
                     op_write ? wr_data : {DATA_W{1'b1}}};
    end

    // Select the current bit cycle's line values.
    always_comb begin
        mdo  = frame_vec[(FRAME_BITS-1) - int'(bit_idx)];
        mdoe = op_write ? 1'b1 : oe_read[(FRAME_BITS-1) - int'(bit_idx)];
    end
endmodule

// File: rtl/mdio_bb_seq.sv
// Access sequencer: for each bit cycle issues clock-low write, clock-high
// write and readback on the register port, each after a pace tick; merges
// MDI into the read result. Assumes reg_ack arrives for each request.
module mdio_bb_seq
    import mdio_bb_pkg::*;
#(
    parameter int              REG_W    = 16,
    parameter int              BIT_MDO  = 0,
    parameter int              BIT_MDI  = 1,
    parameter int              BIT_MCLK = 2,
    parameter int              BIT_MDOE = 3,
    parameter logic [REG_W-1:0] BASE_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_write,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tick,
    input  logic              mdo,
    input  logic              mdoe,
    output logic              op_q,
    output logic [ADDR_W-1:0] phy_q,
    output logic [ADDR_W-1:0] regad_q,
    output logic [DATA_W-1:0] wd_q,
    output logic [IDX_W-1:0]  bit_idx,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              reg_req,
    output logic              reg_we,
    output logic [REG_W-1:0]  reg_wdata,
    input  logic [REG_W-1:0]  reg_rdata,
    input  logic              reg_ack
);
    localparam logic [REG_W-1:0] CTRL_MASK = (REG_W'(1) << BIT_MDO) | (REG_W'(1) << BIT_MDI)
                                           | (REG_W'(1) << BIT_MCLK) | (REG_W'(1) << BIT_MDOE);
    localparam logic [REG_W-1:0] BASE_KEEP = BASE_VAL & ~CTRL_MASK;
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] DATA_IDX  = IDX_W'(DATA_START);

    seq_state_t          state_q;
    bit_phase_t          phase_q;
    logic [IDX_W-1:0]    idx_q;
    logic [DATA_W-1:0]   shift_q;
    logic [DATA_W-1:0]   rd_q;
    logic                done_q;
    logic                mdi_bit;

    assign mdi_bit = reg_rdata[BIT_MDI];

    // Main sequencer: latch request, step phases and bit cycles on acks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            phase_q <= PH_LO;
            idx_q   <= '0;
            shift_q <= '0;
            rd_q    <= '0;
            done_q  <= 1'b0;
            op_q    <= 1'b0;
            phy_q   <= '0;
            regad_q <= '0;
            wd_q    <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                SQ_IDLE: begin
                    if (start) begin
                        op_q    <= op_write;
                        phy_q   <= phy_addr;
                        regad_q <= reg_addr;
                        wd_q    <= wr_data;
                        idx_q   <= '0;
                        phase_q <= PH_LO;
                        state_q <= SQ_WAIT;
                    end
                end
                SQ_WAIT: begin
                    if (tick) begin
                        state_q <= SQ_ACC;
                    end
                end
                SQ_ACC: begin
                    if (reg_ack) begin
                        state_q <= SQ_WAIT;
                        unique case (phase_q)
                            PH_LO: phase_q <= PH_HI;
                            PH_HI: phase_q <= PH_RD;
                            default: begin
                                phase_q <= PH_LO;
                                if (idx_q >= DATA_IDX) begin
                                    shift_q <= {shift_q[DATA_W-2:0], mdi_bit};
                                end
                                if (idx_q == LAST_IDX) begin
                                    state_q <= SQ_IDLE;
                                    done_q  <= 1'b1;
                                    if (!op_q) begin
                                        rd_q <= {shift_q[DATA_W-2:0], mdi_bit};
                                    end
                                end else begin
                                    idx_q <= idx_q + 1'b1;
                                end
                            end
                        endcase
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // Compose the register write value from base and line bits.
    always_comb begin
        reg_wdata           = BASE_KEEP;
        reg_wdata[BIT_MDO]  = mdo;
        reg_wdata[BIT_MDOE] = mdoe;
        reg_wdata[BIT_MCLK] = (phase_q == PH_HI);
    end

    assign reg_req = (state_q == SQ_ACC);
    assign reg_we  = (phase_q != PH_RD);
    assign busy    = (state_q != SQ_IDLE);
    assign done    = done_q;
    assign rd_data = rd_q;
    assign bit_idx = idx_q;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_ack) |=> (reg_req && $stable(reg_we) && $stable(reg_wdata))); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !reg_req); // R1
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R10
    AST_PACED_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_req) |-> $past(tick)); // R6
    AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_we && !op_q && (idx_q >= IDX_W'(TA_START))) |-> !reg_wdata[BIT_MDOE]); // R3
endmodule

// File: rtl/mdio_bb_engine.sv
// Top: MDIO read/write engine driving a host management register. Joins
// the pace counter, the frame builder and the access sequencer.
// Assumes the register port acknowledges every request within finite time.
module mdio_bb_engine
    import mdio_bb_pkg::*;
#(
    parameter int               PACE_DIV = 4096,
    parameter int               REG_W    = 16,
    parameter int               BIT_MDO  = 0,
    parameter int               BIT_MDI  = 1,
    parameter int               BIT_MCLK = 2,
    parameter int               BIT_MDOE = 3,
    parameter logic [REG_W-1:0] BASE_VAL = 16'h3330
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_write,
    input  logic [4:0]        phy_addr,
    input  logic [4:0]        reg_addr,
    input  logic [15:0]       wr_data,
    output logic              busy,
    output logic              done,
    output logic [15:0]       rd_data,
    output logic              reg_req,
    output logic              reg_we,
    output logic [REG_W-1:0]  reg_wdata,
    input  logic [REG_W-1:0]  reg_rdata,
    input  logic              reg_ack
);
    localparam logic [REG_W-1:0] CTRL_MASK = (REG_W'(1) << BIT_MDO) | (REG_W'(1) << BIT_MDI)
                                           | (REG_W'(1) << BIT_MCLK) | (REG_W'(1) << BIT_MDOE);

    logic              tick;
    logic              mdo;
    logic              mdoe;
    logic              op_q;
    logic [ADDR_W-1:0] phy_q;
    logic [ADDR_W-1:0] regad_q;
    logic [DATA_W-1:0] wd_q;
    logic [IDX_W-1:0]  bit_idx;

    mdio_bb_pacer #(.DIV(PACE_DIV)) u_pacer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (busy),
        .tick  (tick)
    );

    mdio_bb_frame u_frame (
        .op_write (op_q),
        .phy_addr (phy_q),
        .reg_addr (regad_q),
        .wr_data  (wd_q),
        .bit_idx  (bit_idx),
        .mdo      (mdo),
        .mdoe     (mdoe)
    );

    mdio_bb_seq #(
        .REG_W    (REG_W),
        .BIT_MDO  (BIT_MDO),
        .BIT_MDI  (BIT_MDI),
        .BIT_MCLK (BIT_MCLK),
        .BIT_MDOE (BIT_MDOE),
        .BASE_VAL (BASE_VAL)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op_write  (op_write),
        .phy_addr  (phy_addr),
        .reg_addr  (reg_addr),
        .wr_data   (wr_data),
        .tick      (tick),
        .mdo       (mdo),
        .mdoe      (mdoe),
        .op_q      (op_q),
        .phy_q     (phy_q),
        .regad_q   (regad_q),
        .wd_q      (wd_q),
        .bit_idx   (bit_idx),
        .busy      (busy),
        .done      (done),
        .rd_data   (rd_data),
        .reg_req   (reg_req),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .reg_ack   (reg_ack)
    );

    AST_BASE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_we) |-> (((reg_wdata ^ BASE_VAL) & ~CTRL_MASK) == '0 && !reg_wdata[BIT_MDI])); // R5
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(op_q) && $stable(phy_q) && $stable(regad_q) && $stable(wd_q))); // R8
endmodule

// File: tb/mdio_bb_engine_test.sv
// Scoreboard bench: a driver task queues the expected frame per request;
// a register/PHY model captures what the engine sends; a monitor compares
// on each done pulse.
module mdio_bb_engine_test;
    localparam int          PACE = 8;
    localparam logic [15:0] BASE = 16'h3330;
    localparam logic [15:0] CTRL = 16'h000F;

    typedef struct {
        logic [63:0] frame;
        logic [63:0] oe;
        logic        is_write;
        logic [15:0] exp_rd;
        string       tag;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_write = 1'b0;
    logic [4:0]  phy_addr = '0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] wr_data = '0;
    logic        busy, done;
    logic [15:0] rd_data;
    logic        reg_req, reg_we;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata = '0;
    logic        reg_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    int cycle = 0;

    exp_item_t   sb_q[$];
    logic [15:0] phy_pattern = '0;
    logic [15:0] mgmt_reg = BASE;
    logic [63:0] cap_mdo = '0;
    logic [63:0] cap_oe = '0;
    int          edge_cnt = 0;
    int          acc_phase = 0;
    bit          phy_is_read = 0;
    bit          seq_err = 0;
    bit          base_err = 0;
    bit          pace_err = 0;
    int          last_start = -1;
    int          lat = 1;
    bit          txn_done = 0;

    mdio_bb_engine #(.PACE_DIV(PACE), .BASE_VAL(BASE)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_write(op_write),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
        .busy(busy), .done(done), .rd_data(rd_data),
        .reg_req(reg_req), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_ack(reg_ack)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Register and PHY model: acks each access after 1..3 cycles.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && reg_req) begin
                if (last_start >= 0) begin
                    if ((cycle - last_start) < PACE || ((cycle - last_start) % PACE) != 0) pace_err = 1;
                end
                last_start = cycle;
                repeat (lat - 1) @(negedge clk);
                lat = (lat % 3) + 1;
                if (reg_we) begin
                    if (((reg_wdata ^ BASE) & ~CTRL) != 0 || reg_wdata[1]) base_err = 1;
                    if (acc_phase == 0) begin
                        if (reg_wdata[2]) seq_err = 1;
                        acc_phase = 1;
                    end else if (acc_phase == 1) begin
                        if (!reg_wdata[2] || reg_wdata[0] != mgmt_reg[0] || reg_wdata[3] != mgmt_reg[3]) seq_err = 1;
                        cap_mdo = {cap_mdo[62:0], reg_wdata[0]};
                        cap_oe  = {cap_oe[62:0], reg_wdata[3]};
                        edge_cnt++;
                        if (edge_cnt == 36) phy_is_read = (cap_mdo[1:0] == 2'b10);
                        acc_phase = 2;
                    end else begin
                        seq_err = 1;
                    end
                    mgmt_reg = reg_wdata;
                end else begin
                    if (acc_phase != 2) seq_err = 1;
                    acc_phase = 0;
                    reg_rdata = mgmt_reg;
                    if (phy_is_read && edge_cnt >= 49)
                        reg_rdata[1] = phy_pattern[64 - edge_cnt];
                    else
                        reg_rdata[1] = 1'b1;
                end
                reg_ack = 1'b1;
                @(negedge clk);
                reg_ack = 1'b0;
            end
        end
    end

    // Monitor: on each done pulse pop the expected item and compare.
    initial begin
        exp_item_t it;
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                if (sb_q.size() == 0) begin
                    check(0, "R10 unexpected done", 64'(1), 64'(0));
                end else begin
                    it = sb_q.pop_front();
                    check(edge_cnt == 64, {"R1 bit cycle count ", it.tag}, 64'(edge_cnt), 64'd64);
                    check(!seq_err, {"R1 access order ", it.tag}, 64'(seq_err), 64'd0);
                    check(cap_mdo == it.frame, {"R2 R8 frame bits ", it.tag}, cap_mdo, it.frame);
                    check(cap_oe == it.oe, {"R3 enable pattern ", it.tag}, cap_oe, it.oe);
                    check(rd_data == it.exp_rd, {"R4 read data ", it.tag}, 64'(rd_data), 64'(it.exp_rd));
                    check(!base_err, {"R5 base bits ", it.tag}, 64'(base_err), 64'd0);
                    check(!pace_err, {"R6 pacing ", it.tag}, 64'(pace_err), 64'd0);
                end
                @(negedge clk);
                check(!done && !busy, "R10 done pulse width", {62'd0, done, busy}, 64'd0);
                cap_mdo = '0; cap_oe = '0; edge_cnt = 0; acc_phase = 0;
                phy_is_read = 0; seq_err = 0; base_err = 0; pace_err = 0;
                last_start = -1;
                txn_done = 1;
            end
        end
    end

    logic [15:0] last_rd = '0;

    // Driver: queue expectation, pulse start, optionally inject a busy start.
    task automatic run_txn(input bit w, input logic [4:0] pa, input logic [4:0] ra,
                           input logic [15:0] wd, input logic [15:0] pat,
                           input bit inject, input string tag);
        exp_item_t it;
        it.frame    = {32'hFFFF_FFFF, 2'b01, w ? 2'b01 : 2'b10, pa, ra,
                       w ? 2'b10 : 2'b11, w ? wd : 16'hFFFF};
        it.oe       = w ? {64{1'b1}} : {{46{1'b1}}, 18'd0};
        it.is_write = w;
        if (!w) last_rd = pat;
        it.exp_rd   = last_rd;
        it.tag      = tag;
        sb_q.push_back(it);
        phy_pattern = pat;
        txn_done = 0;
        @(negedge clk);
        op_write = w; phy_addr = pa; reg_addr = ra; wr_data = wd; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (inject) begin
            repeat (40) @(negedge clk);
            op_write = ~w; phy_addr = ~pa; reg_addr = ~ra; wr_data = ~wd; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait (txn_done);
        repeat (3) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        forever begin
            @(posedge clk);
            cycle++;
            if (cycle > 100000) begin
                check(0, "watchdog expired", 64'(cycle), 64'd100000);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check(!busy, "R9 busy after reset", 64'(busy), 64'd0);
        check(!done, "R9 done after reset", 64'(done), 64'd0);
        check(!reg_req, "R9 reg_req after reset", 64'(reg_req), 64'd0);
        check(rd_data == 16'h0, "R9 rd_data after reset", 64'(rd_data), 64'd0);
        repeat (20) @(negedge clk);
        check(!reg_req, "R1 no access while idle", 64'(reg_req), 64'd0);

        run_txn(1'b0, 5'h01, 5'h00, 16'h0000, 16'hA5C3, 1'b0, "read A5C3");
        run_txn(1'b1, 5'h1F, 5'h00, 16'h8000, 16'h0000, 1'b0, "write 8000");
        run_txn(1'b0, 5'h00, 5'h1F, 16'h0000, 16'h0001, 1'b0, "read 0001");
        run_txn(1'b1, 5'h15, 5'h0A, 16'hFFFF, 16'h1234, 1'b1, "write FFFF busy start");
        run_txn(1'b0, 5'h0A, 5'h15, 16'h0000, 16'hFFFF, 1'b1, "read FFFF busy start");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule